// File: doc/BRIEF.md
# Output Port Register with Atomic Bit Set/Clear

This block is the output side of a 16-pin general-purpose port. A simple 32-bit register bus (address, write enable, byte strobes, write data, combinational read data) reaches two word-sized registers. The output data register can be read and written and drives the 16 output pins directly. The set/clear register is write-only. One write to it carries a set mask and a clear mask, and it changes only the pins those masks name, so no read-modify-write is needed.

Software uses the data register to load the whole port at once. It uses the set/clear register when several agents share the port and each owns only some pins. A single word write then raises or drops any group of bits without disturbing the others. When one write asks to both set and clear the same bit, the set wins.

Top module: `gpo_port_reg`

## Requirements
- R1: An active-low synchronous reset drives all 16 output pins to 0, and the data register then reads as 0x0000_0000.
- R2: A full-word write (all four byte strobes high) to offset 0x0C loads write data bits 15:0 into the output data register. The new value is on the pins from the next cycle.
- R3: A read at offset 0x0C returns the output data register in bits 15:0 and 0 in bits 31:16. Write data bits 31:16 sent to that offset are discarded.
- R4: A full-word write to offset 0x10 treats write data bit y (y = 0..15) as a set request and bit 16+y as a clear request for pin y. A 1 requests the action and a 0 requests nothing. Pins not named in either mask keep their value.
- R5: When the set and clear requests for the same pin are both 1 in one write to offset 0x10, the pin becomes 1.
- R6: A write to either register with any byte strobe low is ignored and the pins keep their value.
- R7: A read at offset 0x10, or at any offset other than 0x0C, returns 0x0000_0000.
- R8: A write to any offset other than 0x0C and 0x10 leaves the pins unchanged.
- R9: A set/clear write takes effect on the same clock edge that accepts it. The pins hold their old value until that edge and show the new value right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | 8 | Byte offset of the accessed register |
| busWe | input | 1 | 1 = write, 0 = read |
| busStrb | input | 4 | Byte strobes; a write needs all four high |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| pinOut | output | 16 | Output pin values |

## Verification
The set/clear path is driven with disjoint set and clear masks on a non-trivial background value. This shows that both masks act and that untouched bits survive. It is also driven with overlapping masks, which tells a set-priority merge from a clear-priority one, and with an all-zero word, which must change nothing. Whole-port loads with ones in the upper half tell a truncating register from one that keeps or reflects those bits. Partial-strobe and unmapped-offset writes tell a proper decode from one that ignores the strobes or part of the address. A pin check just before and just after the accepting edge fixes the one-cycle update timing.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  // Strobes from the decode logic to the register datapath
  typedef struct packed {
    logic wrOut;     // full-word write of the output data register
    logic wrSetClr;  // full-word write of the set/clear register
    logic rdOut;     // read select of the output data register
  } gpoStb_t;
endpackage

// File: rtl/gpo_ctrl.sv
module gpo_ctrl
  import gpo_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int STRB_W     = 4,
  parameter logic [ADDR_W-1:0] OUT_OFS    = 8'h0C,
  parameter logic [ADDR_W-1:0] SETCLR_OFS = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [STRB_W-1:0] busStrb,
  output gpoStb_t           stb
);
  logic fullWord;
  logic hitOut;
  logic hitSetClr;

  always_comb begin
    fullWord     = &busStrb;
    hitOut       = (busAddr == OUT_OFS);
    hitSetClr    = (busAddr == SETCLR_OFS);
    stb.wrOut    = busWe && fullWord && hitOut;
    stb.wrSetClr = busWe && fullWord && hitSetClr;
    stb.rdOut    = !busWe && hitOut;
  end

  AST_PARTIAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !(&busStrb)) |-> (!stb.wrOut && !stb.wrSetClr)); // R6
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrOut, stb.wrSetClr})); // R8
  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != OUT_OFS && busAddr != SETCLR_OFS) |-> !(stb.wrOut || stb.wrSetClr)); // R8
endmodule

// File: rtl/gpo_datapath.sv
module gpo_datapath
  import gpo_pkg::*;
#(
  parameter int PIN_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpoStb_t           stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [PIN_W-1:0]  pins
);
  localparam int PAD_W = DATA_W - PIN_W;

  logic [PIN_W-1:0] outQ;
  logic [PIN_W-1:0] outNext;
  logic [PIN_W-1:0] setMask;
  logic [PIN_W-1:0] clrMask;
  logic             pastValid;

  assign setMask = wdata[PIN_W-1:0];
  assign clrMask = wdata[2*PIN_W-1:PIN_W];

  // Per-bit merge: a set request outranks a clear request
  for (genvar b = 0; b < PIN_W; b++) begin : g_bit
    always_comb begin
      if (stb.wrOut)
        outNext[b] = wdata[b];
      else if (stb.wrSetClr && setMask[b])
        outNext[b] = 1'b1;
      else if (stb.wrSetClr && clrMask[b])
        outNext[b] = 1'b0;
      else
        outNext[b] = outQ[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outQ <= '0;
    else       outQ <= outNext;
  end

  always_ff @(posedge clk) pastValid <= 1'b1;

  assign pins  = outQ;
  assign rdata = stb.rdOut ? {{PAD_W{1'b0}}, outQ} : '0;

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(!rstN)) |-> (outQ == '0)); // R1
  AST_SET_APPLIED: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSetClr |=> ((outQ & $past(setMask)) == $past(setMask))); // R5
  AST_CLR_APPLIED: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSetClr |=> ((outQ & ($past(clrMask) & ~$past(setMask))) == '0)); // R4
  AST_UNNAMED_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSetClr |=> (((outQ ^ $past(outQ)) & ~($past(setMask) | $past(clrMask))) == '0)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.wrOut && !stb.wrSetClr) |=> $stable(outQ)); // R8
  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrOut |=> (outQ == $past(wdata[PIN_W-1:0]))); // R2
endmodule

// File: rtl/gpo_port_reg.sv
module gpo_port_reg
  import gpo_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PIN_W  = 16,
  parameter logic [ADDR_W-1:0] OUT_OFS    = 8'h0C,
  parameter logic [ADDR_W-1:0] SETCLR_OFS = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W/8-1:0] busStrb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [PIN_W-1:0]  pinOut
);
  localparam int STRB_W = DATA_W / 8;

  gpoStb_t stb;

  gpo_ctrl #(
    .ADDR_W(ADDR_W), .STRB_W(STRB_W),
    .OUT_OFS(OUT_OFS), .SETCLR_OFS(SETCLR_OFS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busWe(busWe), .busStrb(busStrb), .stb(stb)
  );

  gpo_datapath #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wdata(busWdata), .rdata(busRdata), .pins(pinOut)
  );
endmodule

// File: tb/sim_gpo_port_reg.sv
module sim_gpo_port_reg;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [3:0]  busStrb = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] pinOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  gpo_port_reg u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busStrb(busStrb), .busWdata(busWdata), .busRdata(busRdata), .pinOut(pinOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // Drive one write at the falling edge; it is accepted at the next rising edge
  task automatic busWrite(input logic [7:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busStrb = s; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busStrb = '0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #1 d = busRdata;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1 pins after reset", {16'h0, pinOut}, 32'h0);
    busRead(8'h0C, r);
    check("R1 data reg after reset", r, 32'h0);
  endtask

  task automatic t_load();
    logic [31:0] r;
    busWrite(8'h0C, 4'hF, 32'hFFFF_A5C3);
    check("R2 pins after load", {16'h0, pinOut}, 32'h0000_A5C3);
    busRead(8'h0C, r);
    check("R3 readback upper zero", r, 32'h0000_A5C3);
  endtask

  task automatic t_setClr();
    logic [31:0] r;
    // background A5C3: set 0F00, clear 00F0 -> AF03
    busWrite(8'h10, 4'hF, 32'h00F0_0F00);
    check("R4 disjoint set/clear", {16'h0, pinOut}, 32'h0000_AF03);
    busRead(8'h0C, r);
    check("R4 readback after set/clear", r, 32'h0000_AF03);
    busWrite(8'h10, 4'hF, 32'h0000_0000);
    check("R4 zero masks no effect", {16'h0, pinOut}, 32'h0000_AF03);
  endtask

  task automatic t_setWins();
    busWrite(8'h0C, 4'hF, 32'h0000_0000);
    busWrite(8'h10, 4'hF, 32'hFFFF_00AA);
    check("R5 set outranks clear", {16'h0, pinOut}, 32'h0000_00AA);
  endtask

  task automatic t_partial();
    busWrite(8'h0C, 4'h7, 32'h0000_1234);
    check("R6 partial strobe data reg", {16'h0, pinOut}, 32'h0000_00AA);
    busWrite(8'h10, 4'hE, 32'h00AA_FF00);
    check("R6 partial strobe set/clear", {16'h0, pinOut}, 32'h0000_00AA);
  endtask

  task automatic t_reads();
    logic [31:0] r;
    busRead(8'h10, r);
    check("R7 set/clear reads zero", r, 32'h0);
    busRead(8'h04, r);
    check("R7 unmapped 0x04 reads zero", r, 32'h0);
    busRead(8'h0D, r);
    check("R7 unaligned 0x0D reads zero", r, 32'h0);
  endtask

  task automatic t_unmapped();
    busWrite(8'h08, 4'hF, 32'hFFFF_FFFF);
    busWrite(8'h14, 4'hF, 32'h00FF_FF00);
    busWrite(8'h8C, 4'hF, 32'h0000_5555);
    check("R8 unmapped writes ignored", {16'h0, pinOut}, 32'h0000_00AA);
  endtask

  task automatic t_timing();
    @(negedge clk);
    busAddr = 8'h10; busWe = 1'b1; busStrb = 4'hF; busWdata = 32'h00AA_0F00;
    #1 check("R9 pins before edge", {16'h0, pinOut}, 32'h0000_00AA);
    @(posedge clk);
    #1 check("R9 pins right after edge", {16'h0, pinOut}, 32'h0000_0F00);
    @(negedge clk);
    busWe = 1'b0; busStrb = '0; busWdata = '0;
  endtask

  task automatic t_midReset();
    logic [31:0] r;
    busWrite(8'h0C, 4'hF, 32'h0000_FFFF);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 pins after mid-run reset", {16'h0, pinOut}, 32'h0);
    busRead(8'h0C, r);
    check("R1 data reg after mid-run reset", r, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_load();
    t_setClr();
    t_setWins();
    t_partial();
    t_reads();
    t_unmapped();
    t_timing();
    t_midReset();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule